// File: doc/BRIEF.md
# I2C Bus-Clear Recovery Sequencer

This block brings a hung I2C bus back to idle. A target can be left mid-byte and hold SDA low. When that happens, the sequencer clocks SCL until the target lets go. It then frames the bus with a start condition followed by a stop condition. The block works on the two bus lines through a direct-control path. Two release bits go out, one per line, where 1 lets the line float high and 0 pulls it low. Two sensed-level bits come back from the pads. While the sequence runs, the block also holds the neighbouring byte-transfer controller in soft reset.

A single-cycle `start_i` launches the sequence. The block first gives an in-flight transfer a bounded chance to complete by polling `xfer_busy_i`. It then releases both lines and reads them back through a synchronizer. If the bus is not idle, it issues up to a fixed number of SCL pulses, re-reading the lines after each one. Next it drives the start/stop pair and lets the controller out of reset. It finishes with a settle delay, a one-cycle `done_o` and a sticky `ok_o` verdict. Every delay is given in microseconds and converted to clock cycles from a clock-frequency parameter, so a simulation can use very short values.

Top module: `i2c_bus_clear`

## Requirements
- R1: After a synchronous reset, `line_drv_o` is 2'b11 (both lines released), and `ctrl_rst_o`, `busy_o`, `done_o` and `ok_o` are all 0.
- R2: When `start_i` is accepted in idle, the block samples `xfer_busy_i` once per check.
  - If the flag is 0, the poll ends immediately.
  - Otherwise the block waits POLL_GAP cycles and checks again, for at most POLL_TRIES checks, and then proceeds regardless.
  - `ctrl_rst_o` rises on the cycle after the poll ends. With the flag clear this is 2 cycles after the start edge; with the flag held high it is 9·GAP+11 cycles for 10 tries.
- R3: `ctrl_rst_o` is high from the end of the poll until the stop condition has been driven. It is low during the final settle and whenever `done_o` is high.
- R4: Line-check encoding: `line_drv_o[1]` is the SDA release and `line_drv_o[0]` is the SCL release. `line_sense_i[1]` is the sensed SDA level and `line_sense_i[0]` is the sensed SCL level.
  - The block releases both lines and samples them through the synchronizer.
  - The bus counts as idle only when both sensed bits are 1.
  - An idle bus receives no SCL pulses.
- R5: Each SCL pulse drives `line_drv_o` = 2'b10 (SCL low, SDA released) for HALF cycles, then 2'b11 for HALF cycles, and is then followed by a new line check. SDA is never driven while SCL is low.
- R6: At most MAX_PULSES SCL pulses are issued per sequence. When the lines read idle, pulsing stops and the start phase follows.
- R7: After the pulse phase, the block drives the bus events in this order, each lasting HOLD cycles:
  - a start: `line_drv_o` = 2'b01 (SDA low, SCL released);
  - a stop: 2'b11;
  - a settle, with the controller released.
- R8: At the end of the sequence, `done_o` pulses for exactly one cycle.
  - `ok_o` is 1 if the last line check saw both lines high, and 0 if the lines were still not idle after MAX_PULSES pulses.
  - `ok_o` holds until the next accepted start, which clears it.
- R9: `start_i` is ignored while a sequence is running. `busy_o` stays high from acceptance until the `done_o` cycle, inclusive.
- R10: `line_drv_o` never takes the value 2'b00 (both lines driven low).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Single-cycle request to run the recovery sequence |
| xfer_busy_i | input | 1 | Pending-transfer flag from the byte-transfer controller |
| line_sense_i | input | 2 | Sensed pad levels: [1] SDA, [0] SCL |
| line_drv_o | output | 2 | Line release controls: [1] SDA, [0] SCL; 1 = released, 0 = pulled low |
| ctrl_rst_o | output | 1 | Soft reset held on the byte-transfer controller |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| ok_o | output | 1 | Bus verdict of the last sequence; 1 = lines found idle |

## Verification
The checker watches the safety rules on every cycle:
- the both-low drive code never appears;
- SDA stays released while SCL is low, and SCL stays high while SDA is low;
- the pulse count per sequence stays within the cap;
- `done_o` lasts one cycle and ends `busy_o`;
- the controller reset is confined to the busy window;
- `ok_o` holds between sequences.

Only the bench scenarios can show the rest:
- the poll duration with the transfer flag clear and with it stuck;
- that the number of pulses tracks how long a modelled target keeps SDA low, including exactly at the cap and beyond it;
- that pulses, start, stop and done come in that order with the right durations;
- that a second `start_i` during a run leaves the event stream unchanged.

// File: rtl/busclr_pkg.sv
package busclr_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_POLL,
    ST_POLL_GAP,
    ST_CHECK,
    ST_SCL_LO,
    ST_SCL_HI,
    ST_START,
    ST_STOP,
    ST_SETTLE,
    ST_DONE
  } seq_st_e;

  // line_drv encoding: [1] SDA release, [0] SCL release
  localparam logic [1:0] DRV_FREE   = 2'b11;
  localparam logic [1:0] DRV_SCL_LO = 2'b10;
  localparam logic [1:0] DRV_SDA_LO = 2'b01;

  function automatic int us_to_cyc(input int hz, input int us);
    int c;
    c = (hz / 1000) * us / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/busclr_sync.sv
module busclr_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= '1;
        else     stg[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= '1;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/busclr_timer.sv
module busclr_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] val,
  output logic          expired
);

  logic [CW-1:0] cnt;

  // Loaded on state entry with val-1: the state lasts exactly val cycles.
  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= val - 1'b1;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/busclr_ctrl.sv
module busclr_ctrl
  import busclr_pkg::*;
#(
  parameter int POLL_TRIES = 10,
  parameter int MAX_PULSES = 10,
  parameter int GAP_C      = 4,
  parameter int HALF_C     = 4,
  parameter int HOLD_C     = 4,
  parameter int SAMPLE_C   = 3,
  parameter int CW         = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          xfer_busy_i,
  input  logic          lines_ok,
  input  logic          tmr_done,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic [1:0]    line_drv_o,
  output logic          ctrl_rst_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          ok_o
);

  localparam int TRY_W = $clog2(POLL_TRIES + 1);
  localparam int PUL_W = $clog2(MAX_PULSES + 1);

  seq_st_e           state, state_n;
  logic [TRY_W-1:0]  tries;
  logic [PUL_W-1:0]  pulses;
  logic              clear_ok;
  logic              accept;

  assign accept = (state == ST_IDLE) && start_i;

  always_comb begin
    state_n = state;
    unique case (state)
      ST_IDLE:     if (start_i) state_n = ST_POLL;
      ST_POLL:     if (!xfer_busy_i || tries == TRY_W'(POLL_TRIES - 1)) state_n = ST_CHECK;
                   else state_n = ST_POLL_GAP;
      ST_POLL_GAP: if (tmr_done) state_n = ST_POLL;
      ST_CHECK:    if (tmr_done) begin
                     if (lines_ok || pulses == PUL_W'(MAX_PULSES)) state_n = ST_START;
                     else state_n = ST_SCL_LO;
                   end
      ST_SCL_LO:   if (tmr_done) state_n = ST_SCL_HI;
      ST_SCL_HI:   if (tmr_done) state_n = ST_CHECK;
      ST_START:    if (tmr_done) state_n = ST_STOP;
      ST_STOP:     if (tmr_done) state_n = ST_SETTLE;
      ST_SETTLE:   if (tmr_done) state_n = ST_DONE;
      ST_DONE:     state_n = ST_IDLE;
      default:     state_n = ST_IDLE;
    endcase
  end

  assign tmr_load = (state_n != state);

  always_comb begin
    unique case (state_n)
      ST_POLL_GAP:                    tmr_val = CW'(GAP_C);
      ST_CHECK:                       tmr_val = CW'(SAMPLE_C);
      ST_SCL_LO, ST_SCL_HI:           tmr_val = CW'(HALF_C);
      ST_START, ST_STOP, ST_SETTLE:   tmr_val = CW'(HOLD_C);
      default:                        tmr_val = CW'(1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      tries      <= '0;
      pulses     <= '0;
      clear_ok   <= 1'b0;
      line_drv_o <= DRV_FREE;
      ctrl_rst_o <= 1'b0;
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
      ok_o       <= 1'b0;
    end else begin
      state <= state_n;

      if (accept)                                          tries <= '0;
      else if (state == ST_POLL && state_n == ST_POLL_GAP) tries <= tries + 1'b1;

      if (accept)                                          pulses <= '0;
      else if (state_n == ST_SCL_LO && state != ST_SCL_LO) pulses <= pulses + 1'b1;

      if (state == ST_CHECK && tmr_done) clear_ok <= lines_ok;

      unique case (state_n)
        ST_SCL_LO: line_drv_o <= DRV_SCL_LO;
        ST_START:  line_drv_o <= DRV_SDA_LO;
        default:   line_drv_o <= DRV_FREE;
      endcase

      ctrl_rst_o <= (state_n == ST_CHECK)  || (state_n == ST_SCL_LO) ||
                    (state_n == ST_SCL_HI) || (state_n == ST_START)  ||
                    (state_n == ST_STOP);
      busy_o     <= (state_n != ST_IDLE);
      done_o     <= (state_n == ST_DONE);

      if (accept)                  ok_o <= 1'b0;
      else if (state_n == ST_DONE) ok_o <= clear_ok;
    end
  end

endmodule

// File: rtl/i2c_bus_clear.sv
module i2c_bus_clear #(
  parameter int CLK_HZ      = 100_000_000,
  parameter int POLL_TRIES  = 10,
  parameter int POLL_GAP_US = 500,
  parameter int MAX_PULSES  = 10,
  parameter int HALF_US     = 100,
  parameter int HOLD_US     = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       xfer_busy_i,
  input  logic [1:0] line_sense_i,
  output logic [1:0] line_drv_o,
  output logic       ctrl_rst_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       ok_o
);

  localparam int GAP_C    = busclr_pkg::us_to_cyc(CLK_HZ, POLL_GAP_US);
  localparam int HALF_C   = busclr_pkg::us_to_cyc(CLK_HZ, HALF_US);
  localparam int HOLD_C   = busclr_pkg::us_to_cyc(CLK_HZ, HOLD_US);
  localparam int SAMPLE_C = SYNC_STAGES + 1;
  localparam int MAX_C    = busclr_pkg::max_of4(GAP_C, HALF_C, HOLD_C, SAMPLE_C);
  localparam int CW       = $clog2(MAX_C + 1);

  logic [1:0]    sense_s;
  logic          tmr_load, tmr_done;
  logic [CW-1:0] tmr_val;

  busclr_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (line_sense_i),
    .dout (sense_s)
  );

  busclr_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .val     (tmr_val),
    .expired (tmr_done)
  );

  busclr_ctrl #(
    .POLL_TRIES (POLL_TRIES),
    .MAX_PULSES (MAX_PULSES),
    .GAP_C      (GAP_C),
    .HALF_C     (HALF_C),
    .HOLD_C     (HOLD_C),
    .SAMPLE_C   (SAMPLE_C),
    .CW         (CW)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .xfer_busy_i (xfer_busy_i),
    .lines_ok    (&sense_s),
    .tmr_done    (tmr_done),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .line_drv_o  (line_drv_o),
    .ctrl_rst_o  (ctrl_rst_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .ok_o        (ok_o)
  );

endmodule

// File: rtl/busclr_chk.sv
module busclr_chk #(
  parameter int MAX_PULSES = 10
) (
  input logic       clk,
  input logic       rst,
  input logic       start_i,
  input logic [1:0] line_drv_o,
  input logic       ctrl_rst_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       ok_o
);

  logic pscl;
  int   nfall;

  always_ff @(posedge clk) begin
    if (rst) begin
      pscl  <= 1'b1;
      nfall <= 0;
    end else begin
      pscl <= line_drv_o[0];
      if (!busy_o)                      nfall <= 0;
      else if (pscl && !line_drv_o[0]) nfall <= nfall + 1;
    end
  end

  a_r1_idle_after_reset: assert property (@(posedge clk)
    rst |=> (line_drv_o == 2'b11 && !ctrl_rst_o && !busy_o && !done_o && !ok_o));

  a_r10_never_both_low: assert property (@(posedge clk) disable iff (rst)
    line_drv_o != 2'b00);

  a_r5_sda_free_while_scl_low: assert property (@(posedge clk) disable iff (rst)
    !line_drv_o[0] |-> line_drv_o[1]);

  a_r7_scl_high_while_sda_low: assert property (@(posedge clk) disable iff (rst)
    !line_drv_o[1] |-> line_drv_o[0]);

  a_r6_pulse_cap: assert property (@(posedge clk) disable iff (rst)
    nfall <= MAX_PULSES);

  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !busy_o);

  a_r8_ok_held_idle: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !start_i) |=> $stable(ok_o));

  a_r3_ctrl_free_at_done: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !ctrl_rst_o);

  a_r3_ctrl_rst_in_busy: assert property (@(posedge clk) disable iff (rst)
    ctrl_rst_o |-> busy_o);

  a_r9_busy_until_done: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !done_o) |=> busy_o);

endmodule

bind i2c_bus_clear busclr_chk #(.MAX_PULSES(MAX_PULSES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .line_drv_o (line_drv_o),
  .ctrl_rst_o (ctrl_rst_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .ok_o       (ok_o)
);

// File: tb/i2c_bus_clear_bench.sv
`timescale 1ns/1ps
module i2c_bus_clear_bench;

  localparam int CLK_HZ = 1_000_000;  // 1 cycle per us for short runs
  localparam int GAP    = 20;
  localparam int HALF   = 4;
  localparam int HOLD   = 30;
  localparam int TRIES  = 10;
  localparam int MAXP   = 10;

  typedef enum int {K_PULSE, K_START, K_STOP, K_DONE} kind_e;
  typedef struct {
    kind_e k;
    logic  ok;
  } ev_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       xbusy = 1'b0;
  logic [1:0] drv;
  logic [1:0] sense;
  logic       crst, busy, done, ok;

  int  hold_n   = 0;
  int  falls    = 0;
  int  checks   = 0;
  int  errors   = 0;
  int  bad_drv  = 0;
  bit  finished = 0;
  ev_t q[$];

  // Target model: keeps SDA low until it has seen hold_n SCL falls.
  assign sense = {drv[1] && (falls >= hold_n), drv[0]};

  always #2.5 clk = ~clk;

  i2c_bus_clear #(
    .CLK_HZ(CLK_HZ), .POLL_TRIES(TRIES), .POLL_GAP_US(GAP),
    .MAX_PULSES(MAXP), .HALF_US(HALF), .HOLD_US(HOLD), .SYNC_STAGES(2)
  ) u_i2c_bus_clear (
    .clk(clk), .rst(rst), .start_i(start), .xfer_busy_i(xbusy),
    .line_sense_i(sense), .line_drv_o(drv), .ctrl_rst_o(crst),
    .busy_o(busy), .done_o(done), .ok_o(ok)
  );

  task automatic chk(input bit cond, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic pop_expect(input kind_e k, input logic okv);
    ev_t e;
    if (q.size() == 0) begin
      chk(0, "R6", "unexpected bus event", int'(k), -1);
    end else begin
      e = q.pop_front();
      chk(e.k == k, "R6/R7", "event order", int'(k), int'(e.k));
      if (k == K_DONE) chk(okv == e.ok, "R8", "ok verdict", int'(okv), int'(e.ok));
    end
  endtask

  // Monitor: classifies drive transitions and compares with the queue.
  initial begin
    logic [1:0] pd;
    logic       pdone;
    int         cyc, t_lo, t_start, t_stop;
    pd = 2'b11; pdone = 1'b0; cyc = 0; t_lo = 0; t_start = 0; t_stop = 0;
    forever begin
      @(posedge clk); #1;
      cyc++;
      if (!rst) begin
        if (drv == 2'b00) bad_drv++;
        if (pd == 2'b11 && drv == 2'b10) begin
          falls++;
          t_lo = cyc;
          pop_expect(K_PULSE, 1'b0);
        end
        if (pd == 2'b10 && drv == 2'b11)
          chk(cyc - t_lo == HALF, "R5", "SCL low width", cyc - t_lo, HALF);
        if (pd == 2'b11 && drv == 2'b01) begin
          t_start = cyc;
          pop_expect(K_START, 1'b0);
          chk(crst == 1'b1, "R3", "controller reset at start", int'(crst), 1);
        end
        if (pd == 2'b01 && drv == 2'b11) begin
          t_stop = cyc;
          chk(cyc - t_start == HOLD, "R7", "start hold", cyc - t_start, HOLD);
          pop_expect(K_STOP, 1'b0);
        end
        if (done && !pdone) begin
          pop_expect(K_DONE, ok);
          chk(cyc - t_stop == 2 * HOLD, "R7", "stop+settle", cyc - t_stop, 2 * HOLD);
          chk(crst == 1'b0, "R3", "controller released at done", int'(crst), 0);
        end
      end
      pd = drv;
      pdone = done;
    end
  end

  // Driver: queue the expected events, launch, time the poll, await done.
  task automatic run_case(input int hold, input bit stuck_busy,
                          input int poll_n, input bit restart);
    int  np, k;
    ev_t e;
    hold_n = hold;
    falls  = 0;
    xbusy  = stuck_busy;
    np = (hold > MAXP) ? MAXP : hold;
    for (int i = 0; i < np; i++) begin
      e.k = K_PULSE; e.ok = 1'b0; q.push_back(e);
    end
    e.k = K_START; e.ok = 1'b0; q.push_back(e);
    e.k = K_STOP;  q.push_back(e);
    e.k = K_DONE;  e.ok = (hold <= MAXP); q.push_back(e);

    @(negedge clk) start = 1'b1;
    k = 0;
    while (k < 5000) begin
      @(posedge clk); #1;
      k++;
      if (k == 1) begin
        start = 1'b0;
        chk(busy == 1'b1, "R9", "busy after accept", int'(busy), 1);
        chk(ok == 1'b0, "R8", "ok cleared on start", int'(ok), 0);
      end
      if (crst) break;
    end
    chk(k == poll_n + 1, "R2", "poll length", k, poll_n + 1);
    xbusy = 1'b0;

    if (restart) begin
      repeat (3) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end

    k = 0;
    while (!done && k < 5000) begin
      @(posedge clk); #1;
      k++;
    end
    repeat (3) @(posedge clk);
    #1;
    chk(q.size() == 0, "R6", "missing events", q.size(), 0);
    chk(busy == 1'b0, "R9", "idle after done", int'(busy), 0);
    chk(ok == (hold <= MAXP), "R8", "ok held after done", int'(ok), int'(hold <= MAXP));
    q.delete();
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #1;
    chk(drv == 2'b11, "R1", "reset drive", int'(drv), 3);
    chk(crst == 1'b0, "R1", "reset ctrl_rst", int'(crst), 0);
    chk(busy == 1'b0 && done == 1'b0, "R1", "reset busy/done", int'({busy, done}), 0);
    chk(ok == 1'b0, "R1", "reset ok", int'(ok), 0);

    run_case(0,  1'b0, 1,              1'b0);  // R4: free bus, no pulses
    run_case(3,  1'b0, 1,              1'b0);  // R4/R5: short hang
    run_case(0,  1'b1, 9 * GAP + 10,   1'b0);  // R2: busy flag stuck
    run_case(10, 1'b0, 1,              1'b0);  // R6: frees on the last pulse
    run_case(11, 1'b0, 1,              1'b0);  // R6/R8: still stuck -> not ok
    run_case(40, 1'b0, 1,              1'b0);  // R8: long hang, cap holds
    run_case(2,  1'b0, 1,              1'b1);  // R9: start during run ignored

    chk(bad_drv == 0, "R10", "both-low drive cycles", bad_drv, 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule